// File: doc/BRIEF.md
# Sleep and Standby Power-Down Sequencer

This block sequences the low-power states of a small processor subsystem. A sleep-instruction strobe from the core takes the subsystem out of normal execution. The standby-select bit decides which of two states it enters. The first is a light sleep: the CPU clock stops and the peripherals keep running. The second is a deep standby: both the CPU clock and the peripheral clock stop, and a chosen group of peripherals receives a one-cycle reset pulse. Register state held by the CPU is never reset.

In light sleep the block watches several wake sources and ends the state when one of them qualifies:
- prioritised interrupt requests, each with its own enable, compared against the current mask level;
- a DMA address error;
- NMI;
- a manual reset;
- a power-on reset.

Standby ends only on NMI, a manual reset or a power-on reset. NMI is locked out for a short window after the instruction that enters standby. On every exit the block gives the exception logic a one-cycle strobe together with a 3-bit cause code.

Top module: `pd_seq`

## Requirements
- R1: A sleep strobe in run mode with stby_sel_i low enters sleep (mode_o = 01) one cycle later. In sleep, cpu_clk_en_o is 0 and per_clk_en_o is 1.
- R2: A sleep strobe in run mode with stby_sel_i high enters standby (mode_o = 10) one cycle later. In standby, both clock enables are 0.
- R3: In sleep, an interrupt source i wakes the block only when its level is strictly above mask_lvl_i. The level of source i is irq_lvl_i[i*LW +: LW]. A level equal to or below the mask leaves the block in sleep.
- R4: A requesting source whose irq_en_i bit is 0 never wakes sleep, whatever its level.
- R5: A DMA address error in sleep wakes the block with cause 1.
- R6: A power-on reset request or a manual reset request wakes both sleep and standby, with cause 2 and cause 3 respectively. A power-on reset request leaves the block in run mode on the next cycle from any state. In run mode, either reset request blocks a sleep strobe given in the same cycle.
- R7: In standby, NMI has no effect in the strobe cycle or in the five cycles after it. An NMI in the sixth cycle after the strobe, or later, wakes the block with cause 4. NMI also wakes sleep, with no lockout window.
- R8: per_rst_o is high for exactly one cycle: the first cycle of standby. Entry to sleep never raises it.
- R9: An exit raises wake_stb_o for one cycle, in the first run cycle, and both clock enables are 1 in that cycle. wake_cause_o is 0 whenever wake_stb_o is 0.
- R10: When several wake events arrive in one cycle, the block takes them in this order: power-on reset (2), manual reset (3), NMI (4), DMA address error (1), interrupt (0). Interrupts and DMA errors are ignored in standby.
- R11: mode_o encodes 00 run, 01 sleep, 10 standby, and never shows 11. stby_sel_i is sampled only at a strobe taken in run mode. Strobes and select changes while asleep have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| slp_stb_i | input | 1 | Sleep-instruction strobe |
| stby_sel_i | input | 1 | Standby select: 1 standby, 0 sleep |
| mask_lvl_i | input | LW | Current interrupt mask level |
| irq_req_i | input | NSRC | Interrupt request per source |
| irq_en_i | input | NSRC | Interrupt enable per source |
| irq_lvl_i | input | NSRC*LW | Packed priority levels, source i at [i*LW +: LW] |
| dma_aerr_i | input | 1 | DMA address error event |
| por_req_i | input | 1 | Power-on reset request |
| mrst_req_i | input | 1 | Manual reset request |
| nmi_i | input | 1 | Non-maskable interrupt |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| per_rst_o | output | 1 | One-cycle reset pulse to the chosen peripherals |
| wake_stb_o | output | 1 | Wake strobe to the exception logic |
| wake_cause_o | output | 3 | Wake cause code |
| mode_o | output | 2 | Current mode |

## Verification
A wrong mode register shows up at the clock enables and at mode_o in the very cycle the state is wrong. The bench compares all of these ports against its own model on every cycle.

A lockout counter that is off by one is harder to see. It appears only when NMI lands exactly on the fifth or the sixth cycle of standby. A directed sequence holds NMI across that boundary, so such a fault shows up as a mode mismatch one cycle early or one cycle late.

A wrong priority or a wrong cause encoding shows up at wake_cause_o in the cycle of the wake strobe. The bench drives simultaneous events to expose it.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {MD_RUN = 2'b00, MD_SLEEP = 2'b01, MD_STBY = 2'b10} pd_mode_e;
  typedef enum logic [2:0] {WC_IRQ = 3'd0, WC_DMA = 3'd1, WC_POR = 3'd2,
                            WC_MRST = 3'd3, WC_NMI = 3'd4} pd_cause_e;

  // fixed wake priority: por > mrst > nmi > dma > irq
  function automatic pd_cause_e pick_cause(input logic por, input logic mrst,
                                           input logic nmi, input logic dma);
    if (por)       return WC_POR;
    else if (mrst) return WC_MRST;
    else if (nmi)  return WC_NMI;
    else if (dma)  return WC_DMA;
    else           return WC_IRQ;
  endfunction
endpackage

// File: rtl/pd_irq_qual.sv
module pd_irq_qual #(
  parameter int NSRC = 4,
  parameter int LW   = 4
) (
  input  logic [NSRC-1:0]    req,
  input  logic [NSRC-1:0]    en,
  input  logic [NSRC*LW-1:0] lvl,
  input  logic [LW-1:0]      mask,
  output logic               hit
);
  function automatic logic above_mask(input logic [LW-1:0] l, input logic [LW-1:0] m);
    return l > m;
  endfunction

  logic [NSRC-1:0] src_hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign src_hit[i] = req[i] & en[i] & above_mask(lvl[i*LW +: LW], mask);
  end

  assign hit = |src_hit;
endmodule

// File: rtl/pd_nmi_gate.sv
module pd_nmi_gate #(
  parameter int LOCK = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic blk
);
  localparam int CW = $clog2(LOCK + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(LOCK);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign blk = (cnt_q != '0);
endmodule

// File: rtl/pd_wake_arb.sv
module pd_wake_arb
  import pd_pkg::*;
(
  input  pd_mode_e  mode,
  input  logic      por,
  input  logic      mrst,
  input  logic      nmi,
  input  logic      nmi_blk,
  input  logic      dma,
  input  logic      irq_hit,
  output logic      wake,
  output pd_cause_e cause
);
  logic in_sleep, in_stby, nmi_q, dma_q, irq_q;

  assign in_sleep = (mode == MD_SLEEP);
  assign in_stby  = (mode == MD_STBY);
  assign nmi_q    = nmi & (in_sleep | (in_stby & ~nmi_blk));
  assign dma_q    = dma & in_sleep;
  assign irq_q    = irq_hit & in_sleep;

  assign wake  = ((in_sleep | in_stby) & (por | mrst)) | nmi_q | dma_q | irq_q;
  assign cause = pick_cause(por, mrst, nmi_q, dma_q);
endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pd_pkg::*;
#(
  parameter int NSRC = 4,
  parameter int LW   = 4,
  parameter int LOCK = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slp_stb_i,
  input  logic               stby_sel_i,
  input  logic [LW-1:0]      mask_lvl_i,
  input  logic [NSRC-1:0]    irq_req_i,
  input  logic [NSRC-1:0]    irq_en_i,
  input  logic [NSRC*LW-1:0] irq_lvl_i,
  input  logic               dma_aerr_i,
  input  logic               por_req_i,
  input  logic               mrst_req_i,
  input  logic               nmi_i,
  output logic               cpu_clk_en_o,
  output logic               per_clk_en_o,
  output logic               per_rst_o,
  output logic               wake_stb_o,
  output logic [2:0]         wake_cause_o,
  output logic [1:0]         mode_o
);
  pd_mode_e  mode_q, mode_d;
  pd_cause_e cause;
  logic      irq_hit, nmi_blk, wake, enter_ok, enter_stby, enter_sleep;
  logic      per_rst_q, wake_stb_q;
  logic [2:0] cause_q;

  pd_irq_qual #(.NSRC(NSRC), .LW(LW)) u_qual (
    .req(irq_req_i), .en(irq_en_i), .lvl(irq_lvl_i), .mask(mask_lvl_i), .hit(irq_hit)
  );

  pd_nmi_gate #(.LOCK(LOCK)) u_nmi (
    .clk(clk), .rst_n(rst_n), .load(enter_stby), .blk(nmi_blk)
  );

  pd_wake_arb u_arb (
    .mode(mode_q), .por(por_req_i), .mrst(mrst_req_i), .nmi(nmi_i), .nmi_blk(nmi_blk),
    .dma(dma_aerr_i), .irq_hit(irq_hit), .wake(wake), .cause(cause)
  );

  // strobe only counts in run mode and loses to a reset request
  assign enter_ok    = (mode_q == MD_RUN) & slp_stb_i & ~por_req_i & ~mrst_req_i;
  assign enter_stby  = enter_ok & stby_sel_i;
  assign enter_sleep = enter_ok & ~stby_sel_i;

  always_comb begin
    mode_d = mode_q;
    if (wake || por_req_i) mode_d = MD_RUN;
    else if (enter_stby)   mode_d = MD_STBY;
    else if (enter_sleep)  mode_d = MD_SLEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MD_RUN;
      per_rst_q  <= 1'b0;
      wake_stb_q <= 1'b0;
      cause_q    <= 3'd0;
    end else begin
      mode_q     <= mode_d;
      per_rst_q  <= enter_stby;
      wake_stb_q <= wake;
      cause_q    <= wake ? cause : WC_IRQ;
    end
  end

  assign cpu_clk_en_o = (mode_q == MD_RUN);
  assign per_clk_en_o = (mode_q != MD_STBY);
  assign per_rst_o    = per_rst_q;
  assign wake_stb_o   = wake_stb_q;
  assign wake_cause_o = cause_q;
  assign mode_o       = mode_q;
endmodule

// File: rtl/pd_seq_chk.sv
module pd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       cpu_en,
  input logic       per_en,
  input logic       per_rst,
  input logic       wake_stb,
  input logic [2:0] wake_cause,
  input logic       nmi,
  input logic       nmi_blk,
  input logic       por,
  input logic       mrst,
  input logic       dma,
  input logic       irq_hit
);
  AST_SLEEP_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |-> !cpu_en && per_en); // R1
  AST_STBY_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 |-> !cpu_en && !per_en); // R2
  AST_SLEEP_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 && !irq_hit && !dma && !nmi && !por && !mrst |=> mode == 2'b01); // R3
  AST_DMA_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 && dma && !nmi && !por && !mrst |=> wake_stb && wake_cause == 3'd1); // R5
  AST_POR_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    por |=> mode == 2'b00); // R6
  AST_NMI_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b10 && nmi_blk && !por && !mrst |=> mode == 2'b10); // R7
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    per_rst |-> mode == 2'b10 && $past(mode) == 2'b00); // R8
  AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb |-> cpu_en && per_en && $past(mode) != 2'b00); // R9
  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_stb |-> wake_cause == 3'd0); // R9
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11); // R11
endmodule

bind pd_seq pd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_o), .cpu_en(cpu_clk_en_o), .per_en(per_clk_en_o),
  .per_rst(per_rst_o), .wake_stb(wake_stb_o), .wake_cause(wake_cause_o), .nmi(nmi_i),
  .nmi_blk(nmi_blk), .por(por_req_i), .mrst(mrst_req_i), .dma(dma_aerr_i), .irq_hit(irq_hit)
);

// File: tb/test_pd_seq.sv
`timescale 1ns/1ps
module test_pd_seq;
  localparam int NSRC = 4;
  localparam int LW   = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, slp, sel, dma, por, mrst, nmi;
  logic [LW-1:0] mask;
  logic [NSRC-1:0] req, en;
  logic [NSRC*LW-1:0] lvl;
  logic cpu_en, per_en, per_rst, wstb;
  logic [2:0] wcause;
  logic [1:0] mode;

  pd_seq #(.NSRC(NSRC), .LW(LW), .LOCK(5)) i_pd_seq (
    .clk(clk), .rst_n(rst_n), .slp_stb_i(slp), .stby_sel_i(sel), .mask_lvl_i(mask),
    .irq_req_i(req), .irq_en_i(en), .irq_lvl_i(lvl), .dma_aerr_i(dma), .por_req_i(por),
    .mrst_req_i(mrst), .nmi_i(nmi), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .per_rst_o(per_rst), .wake_stb_o(wstb), .wake_cause_o(wcause), .mode_o(mode)
  );

  int total = 0;
  int bad = 0;
  logic [1:0] em;
  int eage;
  logic estb, erst;
  logic [2:0] ecause;

  function automatic logic irq_ok_f(input logic [NSRC-1:0] r, input logic [NSRC-1:0] e,
                                    input logic [NSRC*LW-1:0] l, input logic [LW-1:0] m);
    logic ok = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (r[i] && e[i] && (int'(l[i*LW +: LW]) > int'(m))) ok = 1'b1;
    return ok;
  endfunction

  function automatic logic [2:0] exp_cause(input logic p, input logic mr, input logic n,
                                           input logic d);
    return p ? 3'd2 : mr ? 3'd3 : n ? 3'd4 : d ? 3'd1 : 3'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [1:0] nm = em;
    int nage = 0;
    logic nstb = 1'b0, nrst = 1'b0;
    logic [2:0] nc = 3'd0;
    logic iok = irq_ok_f(req, en, lvl, mask);
    if (em == 2'b00) begin
      if (!por && !mrst && slp) begin nm = sel ? 2'b10 : 2'b01; nrst = sel; end
    end else if (em == 2'b01) begin
      if (por || mrst || nmi || dma || iok) begin
        nm = 2'b00; nstb = 1'b1; nc = exp_cause(por, mrst, nmi, dma);
      end
    end else begin
      if (por || mrst || (nmi && eage >= 6)) begin
        nm = 2'b00; nstb = 1'b1; nc = exp_cause(por, mrst, nmi, 1'b0);
      end
    end
    if (por) nm = 2'b00;
    if (nm == 2'b10) nage = (em == 2'b10) ? eage + 1 : 1;
    @(posedge clk);
    @(negedge clk);
    em = nm; eage = nage; estb = nstb; erst = nrst; ecause = nc;
    chk("R11 mode", 32'(mode), 32'(em));
    chk("R1 cpu_clk_en", 32'(cpu_en), 32'(em == 2'b00));
    chk("R2 per_clk_en", 32'(per_en), 32'(em != 2'b10));
    chk("R8 per_rst", 32'(per_rst), 32'(erst));
    chk("R9 wake_stb", 32'(wstb), 32'(estb));
    chk("R10 wake_cause", 32'(wcause), 32'(ecause));
  endtask

  task automatic idle();
    slp = 0; sel = 0; dma = 0; por = 0; mrst = 0; nmi = 0;
    mask = '0; req = '0; en = '0; lvl = '0;
  endtask

  task automatic enter(input logic s);
    slp = 1'b1; sel = s; tick(); slp = 1'b0; sel = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle(); rst_n = 1'b0;
    em = 2'b00; eage = 0; estb = 0; erst = 0; ecause = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R11 reset mode", 32'(mode), 0);
    chk("R9 reset cpu_en", 32'(cpu_en), 1);
    chk("R9 reset stb", 32'(wstb), 0);

    // sleep entry and interrupt filtering
    enter(1'b0);
    chk("R1 sleep entered", 32'(mode), 1);
    mask = 4'd5; req = 4'b0001; en = 4'b0001; lvl = 16'h0005;
    tick(); chk("R3 equal level ignored", 32'(mode), 1);
    lvl = 16'h0002;
    tick(); chk("R3 lower level ignored", 32'(mode), 1);
    req = 4'b0010; lvl = 16'h00F0;
    tick(); chk("R4 disabled source ignored", 32'(mode), 1);
    req = '0; slp = 1; sel = 1;
    tick(); chk("R11 strobe while asleep ignored", 32'(mode), 1);
    slp = 0; sel = 0; req = 4'b0001; lvl = 16'h0006;
    tick(); chk("R3 higher level wakes", 32'(mode), 0);
    chk("R9 irq cause", 32'(wcause), 0);
    idle();

    // DMA error
    enter(1'b0); dma = 1; tick(); idle();
    chk("R5 dma cause", 32'(wcause), 1);

    // standby with NMI lockout; irq and dma ignored
    enter(1'b1);
    chk("R8 pulse on entry", 32'(per_rst), 1);
    chk("R2 standby entered", 32'(mode), 2);
    nmi = 1; dma = 1; req = 4'b1111; en = 4'b1111; lvl = 16'hFFFF;
    for (int k = 1; k <= 5; k++) begin
      tick(); chk("R7 nmi locked", 32'(mode), 2);
    end
    chk("R8 pulse single", 32'(per_rst), 0);
    tick(); chk("R7 nmi accepted", 32'(mode), 0);
    chk("R7 nmi cause", 32'(wcause), 4);
    idle();

    // simultaneous events in sleep
    enter(1'b0); mrst = 1; nmi = 1; dma = 1; req = 1; en = 1; lvl = 16'h000F;
    tick(); chk("R10 mrst first", 32'(wcause), 3); idle();
    enter(1'b0); nmi = 1; dma = 1; req = 1; en = 1; lvl = 16'h000F;
    tick(); chk("R10 nmi over dma", 32'(wcause), 4); idle();
    enter(1'b0); dma = 1; req = 1; en = 1; lvl = 16'h000F;
    tick(); chk("R10 dma over irq", 32'(wcause), 1); idle();

    // resets
    enter(1'b1); por = 1; tick(); chk("R6 por leaves standby", 32'(wcause), 2); idle();
    enter(1'b1); mrst = 1; tick(); chk("R6 mrst leaves standby", 32'(wcause), 3); idle();
    por = 1; slp = 1; tick(); chk("R6 por blocks strobe", 32'(mode), 0); idle();
    enter(1'b0); nmi = 1; tick(); chk("R7 nmi wakes sleep", 32'(wcause), 4); idle();

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      slp  = ($urandom % 4) == 0;
      sel  = $urandom % 2;
      por  = ($urandom % 200) == 0;
      mrst = ($urandom % 150) == 0;
      nmi  = ($urandom % 20) == 0;
      dma  = ($urandom % 30) == 0;
      req  = NSRC'($urandom) & NSRC'($urandom) & NSRC'($urandom);
      en   = NSRC'($urandom);
      lvl  = (NSRC*LW)'($urandom);
      mask = LW'($urandom);
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule